// File: doc/BRIEF.md
# Comparator-Driven Threshold Calibration Sequencer

This block finds a detection threshold for a sensor channel by sweeping a DAC against an external comparator. After a start strobe it asks the surrounding system to establish the bright condition, waits for that request to be acknowledged, and then writes DAC codes upward from zero, one code per step. After each write it waits a programmable settling time and then samples a synchronized copy of the comparator. The first code at which the comparator reads high is stored as the bright trip code.

The same sweep then runs again under the dark condition, again gated by a request and acknowledge exchange, and its trip code is stored. The block finally writes the DAC with the integer midpoint of the two stored codes and flags completion for one cycle. If a sweep reaches the top code without a trip, the run is abandoned, the DAC is written back with the code it held before the run, and an error flag is raised.

Top module: `thresh_cal_seq`

## Requirements
- R1: After reset `dac_code_o` is 0 and `dac_wr_o`, `done_o`, `err_o` and `cond_req_o` are all low.
- R2: A `start_i` pulse while idle clears `err_o` and raises `cond_req_o` with `cond_bright_o` high (1 = bright condition, 0 = dark); a `start_i` pulse while a run is in progress is ignored and does not change the result.
- R3: No DAC write occurs while `cond_req_o` is high; the sweep begins only after `cond_ack_i` is seen high during the request.
- R4: Each sweep writes codes 0, 1, 2, ... in order; the trip code is the first written code for which the synchronized `cmp_i` reads high (high = tripped), so a run with bright trip code H and dark trip code D performs exactly H + D + 3 writes.
- R5: `cmp_i` passes through a two-flop synchronizer, and consecutive DAC writes are separated by at least `settle_i` + 3 clock cycles (`settle_i` held constant during a run).
- R6: After the bright trip the block raises `cond_req_o` a second time with `cond_bright_o` low and runs the dark sweep.
- R7: The final write carries (H + D) >> 1 computed with an 11-bit sum, and `done_o` is high for exactly one cycle, in the same cycle as that final `dac_wr_o`.
- R8: If a sweep writes code 1023 without a trip, the block writes the code `dac_code_o` held when the run was started, raises `err_o` together with that write, never pulses `done_o` for the run, and keeps `err_o` high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| settle_i | input | 8 | Extra settling cycles after each DAC write |
| cond_req_o | output | 1 | Request to establish the sweep condition |
| cond_bright_o | output | 1 | Requested condition: 1 bright, 0 dark |
| cond_ack_i | input | 1 | Condition established acknowledge |
| cmp_i | input | 1 | Asynchronous comparator output, high when tripped |
| dac_code_o | output | 10 | Code last written to the DAC |
| dac_wr_o | output | 1 | One-cycle DAC write strobe |
| done_o | output | 1 | One-cycle completion pulse with the final write |
| err_o | output | 1 | Sticky no-trip error flag |

## Verification
A wrong sweep counter or a missed trip shows up directly as a wrong number of write strobes per run and as a wrong final code, visible at the end of the run it corrupts. A settle timer that expires early shows as two write strobes closer than the settle window, on the very next step. A wrong phase or saved-code register surfaces as a dark sweep that never happens, a second request still marked bright, or an error run that restores the wrong code, each visible in the cycle the block acts on that register.

// File: rtl/thresh_cal_pkg.sv
// Shared types for the threshold calibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package thresh_cal_pkg;

    // Sequencer control states.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ASK    = 3'd1,
        ST_STEP   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_COMMIT = 3'd4
    } cal_state_t;

    // Sweep phase: which lighting condition is being measured.
    typedef enum logic {
        PH_BRIGHT = 1'b0,
        PH_DARK   = 1'b1
    } cal_phase_t;

endpackage

// File: rtl/cal_sync.sv
// Multi-flop synchronizer for a single asynchronous bit.
// Assumes: the input is a level that stays stable for several clocks;
// resets to 0 so a comparator reads "not tripped" after reset.
module cal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Each stage samples the previous one (stage 0 samples the pin).
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= d_i;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cal_settle_timer.sv
// Down-counter that measures the settling window after a DAC write.
// Assumes: load is a one-cycle pulse; expired_o is high whenever the
// count has reached zero, including while idle.
module cal_settle_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load_i)     cnt <= load_val_i;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);
endmodule

// File: rtl/cal_midpoint.sv
// Integer midpoint of two codes, using a sum one bit wider than a code.
// Assumes: purely combinational; result rounds toward zero.
module cal_midpoint #(
    parameter int CODE_W = 10
) (
    input  logic [CODE_W-1:0] a_i,
    input  logic [CODE_W-1:0] b_i,
    output logic [CODE_W-1:0] mid_o
);
    localparam int SUM_W = CODE_W + 1;
    logic [SUM_W-1:0] sum;

    // Widen both operands so the top carry is kept before halving.
    always_comb begin
        sum   = {1'b0, a_i} + {1'b0, b_i};
        mid_o = sum[SUM_W-1:1];
    end
endmodule

// File: rtl/thresh_cal_seq.sv
// Threshold calibration sequencer: two upward DAC sweeps (bright, then
// dark) against a comparator, then commits the midpoint of the two trip
// codes. Assumes: settle_i is stable during a run; cmp_i is high when
// the comparator has tripped; the condition handshake is a level request
// answered by an acknowledge.
module thresh_cal_seq #(
    parameter int CODE_W      = 10,
    parameter int SETTLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic                cond_req_o,
    output logic                cond_bright_o,
    input  logic                cond_ack_i,
    input  logic                cmp_i,
    output logic [CODE_W-1:0]   dac_code_o,
    output logic                dac_wr_o,
    output logic                done_o,
    output logic                err_o
);
    import thresh_cal_pkg::*;

    localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};
    localparam int                TMR_W    = SETTLE_W + 1;

    cal_state_t        state;
    cal_phase_t        phase;
    logic [CODE_W-1:0] sweep_code;
    logic [CODE_W-1:0] bright_code;
    logic [CODE_W-1:0] dark_code;
    logic [CODE_W-1:0] saved_code;
    logic [CODE_W-1:0] dac_q;
    logic              wr_q;
    logic              done_q;
    logic              err_q;
    logic              cmp_s;
    logic              tmr_done;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic [CODE_W-1:0] mid_code;
    logic              busy;

    // Comparator crosses into this clock domain here.
    cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (cmp_s)
    );

    // Settle window covers the user delay plus the synchronizer latency.
    always_comb begin
        tmr_load = (state == ST_STEP);
        tmr_val  = {1'b0, settle_i} + TMR_W'(SYNC_STAGES);
    end

    cal_settle_timer #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_done)
    );

    cal_midpoint #(.CODE_W(CODE_W)) u_mid (
        .a_i   (bright_code),
        .b_i   (dark_code),
        .mid_o (mid_code)
    );

    // Main sequencer: handshake, sweep stepping, trip capture, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase       <= PH_BRIGHT;
            sweep_code  <= '0;
            bright_code <= '0;
            dark_code   <= '0;
            saved_code  <= '0;
            dac_q       <= '0;
            wr_q        <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            wr_q   <= 1'b0;
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        err_q      <= 1'b0;
                        saved_code <= dac_q;
                        phase      <= PH_BRIGHT;
                        sweep_code <= '0;
                        state      <= ST_ASK;
                    end
                end
                ST_ASK: begin
                    if (cond_ack_i) state <= ST_STEP;
                end
                ST_STEP: begin
                    dac_q <= sweep_code;
                    wr_q  <= 1'b1;
                    state <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (tmr_done) begin
                        if (cmp_s) begin
                            if (phase == PH_BRIGHT) begin
                                bright_code <= sweep_code;
                                phase       <= PH_DARK;
                                sweep_code  <= '0;
                                state       <= ST_ASK;
                            end else begin
                                dark_code <= sweep_code;
                                state     <= ST_COMMIT;
                            end
                        end else if (sweep_code == CODE_TOP) begin
                            dac_q <= saved_code;
                            wr_q  <= 1'b1;
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            sweep_code <= sweep_code + 1'b1;
                            state      <= ST_STEP;
                        end
                    end
                end
                ST_COMMIT: begin
                    dac_q  <= mid_code;
                    wr_q   <= 1'b1;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port views of the sequencer state.
    always_comb begin
        busy          = (state != ST_IDLE);
        cond_req_o    = (state == ST_ASK);
        cond_bright_o = (state == ST_ASK) && (phase == PH_BRIGHT);
        dac_code_o    = dac_q;
        dac_wr_o      = wr_q;
        done_o        = done_q;
        err_o         = err_q;
    end
endmodule

// File: rtl/thresh_cal_chk.sv
// Protocol checker for the threshold calibration sequencer, bound to
// every instance. Assumes settle_i is stable from start to end of run.
module thresh_cal_chk #(
    parameter int SETTLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                busy,
    input logic [SETTLE_W-1:0] settle_i,
    input logic                cond_req_o,
    input logic                dac_wr_o,
    input logic                done_o,
    input logic                err_o
);
    logic [15:0] since_wr;
    logic        have_wr;

    // Cycles since the last write within the current run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_wr <= '0;
            have_wr  <= 1'b0;
        end else if (start_i && !busy) begin
            since_wr <= '0;
            have_wr  <= 1'b0;
        end else if (dac_wr_o) begin
            since_wr <= 16'd1;
            have_wr  <= 1'b1;
        end else if (since_wr != 16'hFFFF) begin
            since_wr <= since_wr + 16'd1;
        end
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_with_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> dac_wr_o);
    p_no_wr_in_ask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cond_req_o |-> !dac_wr_o);
    p_settle_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_wr_o && have_wr) |-> (since_wr >= (16'(settle_i) + 16'd3)));
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);
    p_err_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !done_o);
endmodule

bind thresh_cal_seq thresh_cal_chk #(.SETTLE_W(SETTLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy       (busy),
    .settle_i   (settle_i),
    .cond_req_o (cond_req_o),
    .dac_wr_o   (dac_wr_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/sim_thresh_cal_seq.sv
// Bench: comparator modelled as "DAC code >= trip level" for the
// condition currently acknowledged; directed corners plus seeded random runs.
module sim_thresh_cal_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] settle = 8'd0;
    logic       req, bright, ack = 1'b0, cmp, wr, done, err;
    logic [9:0] code;
    int         cur_trip = 100000;
    int         n_checks = 0, n_fail = 0;
    int         wr_cnt = 0, done_cnt = 0, since_wr = 0, min_gap = 100000;
    logic [9:0] done_code;
    logic       done_wr;
    localparam int NO_TRIP = 100000;

    always #4 clk = ~clk;

    assign cmp = (int'(code) >= cur_trip);

    thresh_cal_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .settle_i(settle),
        .cond_req_o(req), .cond_bright_o(bright), .cond_ack_i(ack),
        .cmp_i(cmp), .dac_code_o(code), .dac_wr_o(wr),
        .done_o(done), .err_o(err)
    );

    // Port monitor: counts writes, gaps between writes, done pulses.
    always @(negedge clk) begin
        since_wr++;
        if (wr) begin
            if (wr_cnt > 0 && since_wr < min_gap) min_gap = since_wr;
            wr_cnt++;
            since_wr = 0;
        end
        if (done) begin
            done_cnt++;
            done_code = code;
            done_wr   = wr;
        end
    end

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    function automatic int mid_of(input int a, input int b);
        return (a + b) / 2;
    endfunction

    // One calibration run; hi/dk equal NO_TRIP mean no trip in that phase.
    task automatic run_cal(input int hi, input int dk, input int st, input bit busy_start);
        int  prev, n_req, cycles, w0, exp_writes;
        bit  finished, exp_err;
        prev = int'(code);
        settle = 8'(st);
        n_req = 0; cycles = 0; finished = 0;
        wr_cnt = 0; done_cnt = 0; min_gap = 100000;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!finished && cycles < 20000) begin
            if (req) begin
                n_req++;
                if (n_req == 1) chk(bright == 1'b1, "R2 first request bright", int'(bright), 1);
                else            chk(bright == 1'b0, "R6 second request dark", int'(bright), 0);
                cur_trip = (n_req == 1) ? hi : dk;
                w0 = wr_cnt;
                repeat ($urandom_range(0, 4)) @(negedge clk);
                chk(wr_cnt == w0, "R3 no write before ack", wr_cnt, w0);
                ack = 1'b1;
                @(negedge clk) ack = 1'b0;
            end
            if (busy_start && cycles == 40) start = 1'b1;
            if (busy_start && cycles == 41) start = 1'b0;
            @(negedge clk);
            cycles++;
            if (done || err) finished = 1;
        end
        repeat (3) @(negedge clk);
        exp_err = (hi == NO_TRIP) || (dk == NO_TRIP);
        if (!exp_err) begin
            exp_writes = hi + dk + 3;
            chk(err == 1'b0, "R8 no error on good run", int'(err), 0);
            chk(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
            chk(done_wr == 1'b1, "R7 done with write", int'(done_wr), 1);
            chk(int'(done_code) == mid_of(hi, dk), "R7 midpoint", int'(done_code), mid_of(hi, dk));
            chk(int'(code) == mid_of(hi, dk), "R7 final dac code", int'(code), mid_of(hi, dk));
            chk(wr_cnt == exp_writes, "R4 write count", wr_cnt, exp_writes);
            chk(n_req == 2, "R6 two requests", n_req, 2);
        end else begin
            exp_writes = (hi == NO_TRIP) ? 1025 : hi + 1 + 1025;
            chk(err == 1'b1, "R8 error raised", int'(err), 1);
            chk(done_cnt == 0, "R8 no done on error", done_cnt, 0);
            chk(int'(code) == prev, "R8 previous code restored", int'(code), prev);
            chk(wr_cnt == exp_writes, "R4 write count on error", wr_cnt, exp_writes);
        end
        chk(min_gap >= st + 3, "R5 settle gap", min_gap, st + 3);
        chk(req == 1'b0, "R2 idle after run", int'(req), 0);
        cur_trip = NO_TRIP;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code == 10'd0, "R1 reset code", int'(code), 0);
        chk({wr, done, err, req} == 4'b0, "R1 reset flags", int'({wr, done, err, req}), 0);
        run_cal(0, 0, 0, 0);              // R4 trip at first code
        run_cal(5, 900, 2, 0);
        run_cal(NO_TRIP, 0, 0, 0);        // R8 bright sweep never trips
        run_cal(1023, 1023, 1, 0);        // R7 11-bit sum corner
        run_cal(1023, 0, 0, 0);
        run_cal(10, NO_TRIP, 0, 0);       // R8 dark sweep never trips
        run_cal(200, 100, 1, 1);          // R2 start while busy ignored
        for (int i = 0; i < 6; i++)
            run_cal($urandom_range(0, 400), $urandom_range(0, 400), $urandom_range(0, 5), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule